// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

A purely combinational 16-bit adder that takes two operands and a carry-in, and returns a 16-bit sum and a carry-out. No carry ripples from bit to bit or from group to group. Each bit forms a generate term (both operand bits set) and a propagate term (either operand bit set). The bits are split into four 4-bit groups. Each group resolves its own internal carries as flat sums of products and reports a group propagate and a group generate.

A second-level lookahead unit applies the same equations to the four group pairs. It produces the carry into groups 1, 2 and 3 and the final carry-out. The group carry-ins come only from this unit. The sum of each bit is the XOR of the two operand bits and the carry into that bit. The block sits in a datapath where the carry path depth must not grow with the width.

Top module: `cla_adder`

## Requirements
- R1: `sum_o` equals bits 15..0 of the 17-bit value `a_i + b_i + c_i`.
- R2: `c_o` equals bit 16 of the 17-bit value `a_i + b_i + c_i`.
- R3: For k = 4, 8 and 12, the carry into bit k equals bit k of `a_i[k-1:0] + b_i[k-1:0] + c_i`. At the ports this carry reads as `sum_o[k] ^ a_i[k] ^ b_i[k]`.
- R4: When `b_i == ~a_i` and `c_i = 1`, the carry-in passes through all 16 bits: `sum_o = 16'h0000` and `c_o = 1`.
- R5: When `b_i == ~a_i` and `c_i = 0`, `sum_o = 16'hFFFF` and `c_o = 0`.
- R6: When both operands are zero, `sum_o` equals `c_i` (bit 0 only) and `c_o = 0`.
- R7: `16'hFFFF + 16'hFFFF + 1` gives `sum_o = 16'hFFFF` and `c_o = 1`.
- R8: A carry generated in bit 0 passes through groups 1 to 3: `16'h0001 + 16'hFFFF + 0` gives `sum_o = 0` and `c_o = 1`.
- R9: Bits where both operands are set both generate and propagate. For example, `16'h8888 + 16'h8888 + 0` gives `sum_o = 16'h1110` and `c_o = 1`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| c_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits 15..0 |
| c_o | output | 1 | Carry out of bit 15 |

## Verification
Two functions land in the same evaluation: the in-group carry resolution and the second-level carry into a group boundary. Operand pairs are chosen so that both must act at once, for example a generate in group 0 that has to pass through fully propagating groups. These are mixed with random pairs where group boundaries see both generated and propagated carries. Each result is judged on three things against a 17-bit reference addition in the bench: the sum, the carry-out, and the carry recovered at bits 4, 8 and 12.

// File: rtl/cla_pkg.sv
package cla_pkg;
  parameter int unsigned CLA_WIDTH = 16;
  parameter int unsigned CLA_GRP_W = 4;
endpackage

// File: rtl/cla_lookahead.sv
// Flat lookahead: c_o[k] is the carry out of position k, as a sum of products.
module cla_lookahead #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] p_i,
  input  logic [N-1:0] g_i,
  input  logic         c_i,
  output logic [N-1:0] c_o
);
  always_comb begin
    for (int k = 0; k < N; k++) begin
      logic carry_term;
      logic prod;
      carry_term = c_i;
      for (int j = 0; j <= k; j++) carry_term = carry_term & p_i[j];
      for (int j = 0; j <= k; j++) begin
        prod = g_i[j];
        for (int m = j + 1; m <= k; m++) prod = prod & p_i[m];
        carry_term = carry_term | prod;
      end
      c_o[k] = carry_term;
    end
  end
endmodule

// File: rtl/cla_group_pg.sv
module cla_group_pg #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] p_i,
  input  logic [N-1:0] g_i,
  output logic         gp_o,
  output logic         gg_o
);
  always_comb begin
    logic prod;
    gp_o = &p_i;
    gg_o = 1'b0;
    for (int j = 0; j < N; j++) begin
      prod = g_i[j];
      for (int m = j + 1; m < N; m++) prod = prod & p_i[m];
      gg_o = gg_o | prod;
    end
  end
endmodule

// File: rtl/cla_group.sv
module cla_group #(
  parameter int unsigned GRP_W = 4
) (
  input  logic [GRP_W-1:0] a_i,
  input  logic [GRP_W-1:0] b_i,
  input  logic             c_i,
  output logic [GRP_W-1:0] sum_o,
  output logic             gp_o,
  output logic             gg_o
);
  localparam int unsigned NINT = GRP_W - 1;

  logic [GRP_W-1:0] bit_p, bit_g, bit_c;
  logic [NINT-1:0]  int_c;

  assign bit_p = a_i | b_i;
  assign bit_g = a_i & b_i;

  // Only the carries into bits 1..GRP_W-1 are needed here; the group carry-out comes from level two.
  cla_lookahead #(.N(NINT)) i_la (
    .p_i(bit_p[NINT-1:0]),
    .g_i(bit_g[NINT-1:0]),
    .c_i(c_i),
    .c_o(int_c)
  );

  cla_group_pg #(.N(GRP_W)) i_pg (
    .p_i (bit_p),
    .g_i (bit_g),
    .gp_o(gp_o),
    .gg_o(gg_o)
  );

  assign bit_c = {int_c, c_i};
  assign sum_o = a_i ^ b_i ^ bit_c;
endmodule

// File: rtl/cla_adder.sv
module cla_adder
  import cla_pkg::*;
#(
  parameter int unsigned WIDTH = CLA_WIDTH,
  parameter int unsigned GRP_W = CLA_GRP_W
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             c_o
);
  localparam int unsigned N_GRP = WIDTH / GRP_W;

  logic [N_GRP-1:0] grp_p, grp_g;
  logic [N_GRP:0]   grp_c;
  logic [N_GRP-1:0] lvl2_c;

  cla_lookahead #(.N(N_GRP)) i_lvl2 (
    .p_i(grp_p),
    .g_i(grp_g),
    .c_i(c_i),
    .c_o(lvl2_c)
  );

  assign grp_c = {lvl2_c, c_i};
  assign c_o   = grp_c[N_GRP];

  for (genvar gi = 0; gi < N_GRP; gi++) begin : g_grp
    cla_group #(.GRP_W(GRP_W)) i_grp (
      .a_i  (a_i[gi*GRP_W +: GRP_W]),
      .b_i  (b_i[gi*GRP_W +: GRP_W]),
      .c_i  (grp_c[gi]),
      .sum_o(sum_o[gi*GRP_W +: GRP_W]),
      .gp_o (grp_p[gi]),
      .gg_o (grp_g[gi])
    );
  end
endmodule

// File: rtl/cla_adder_chk.sv
module cla_adder_chk #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned GRP_W = 4
) (
  input logic [WIDTH-1:0]       a_i,
  input logic [WIDTH-1:0]       b_i,
  input logic                   c_i,
  input logic [WIDTH-1:0]       sum_o,
  input logic                   c_o,
  input logic [WIDTH/GRP_W:0]   grp_c
);
  localparam int unsigned N_GRP = WIDTH / GRP_W;

  logic [WIDTH:0] ref_sum;
  assign ref_sum = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, c_i};

  always_comb begin
    AST_SUM_MATCH: assert (sum_o == ref_sum[WIDTH-1:0]) else $error("sum mismatch"); // R1
    AST_COUT_MATCH: assert (c_o == ref_sum[WIDTH]) else $error("carry-out mismatch"); // R2
    if ((a_i == '0) && (b_i == '0))
      AST_ZERO_OPS: assert ((c_o == 1'b0) && (sum_o == WIDTH'(c_i))) else $error("zero operands"); // R6
    if ((b_i == ~a_i) && c_i)
      AST_FULL_PROP: assert ((c_o == 1'b1) && (sum_o == '0)) else $error("full propagate"); // R4
  end

  always_comb begin
    for (int k = 1; k < N_GRP; k++) begin
      logic [WIDTH:0] part;
      part = '0;
      for (int j = 0; j < k * GRP_W; j++) begin
        part[j] = a_i[j];
      end
      part = part + ({1'b0, b_i} & ((({{WIDTH{1'b0}}, 1'b1}) << (k * GRP_W)) - 1'b1)) + {{WIDTH{1'b0}}, c_i};
      AST_GROUP_CARRY: assert (grp_c[k] == part[k*GRP_W]) else $error("group carry %0d", k); // R3
    end
  end
endmodule

bind cla_adder cla_adder_chk #(.WIDTH(WIDTH), .GRP_W(GRP_W)) i_cla_adder_chk (
  .a_i  (a_i),
  .b_i  (b_i),
  .c_i  (c_i),
  .sum_o(sum_o),
  .c_o  (c_o),
  .grp_c(grp_c)
);

// File: tb/test_cla_adder.sv
`timescale 1ns/1ps
module test_cla_adder;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] a, b, sum;
  logic        ci, co;
  int          n_vec = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  cla_adder i_cla_adder (.a_i(a), .b_i(b), .c_i(ci), .sum_o(sum), .c_o(co));

  function automatic logic [16:0] ref_add(input logic [15:0] x, input logic [15:0] y, input logic c);
    return {1'b0, x} + {1'b0, y} + {16'h0, c};
  endfunction

  function automatic logic ref_carry(input logic [15:0] x, input logic [15:0] y, input logic c, input int k);
    logic [16:0] mask, t;
    mask = (17'h1 << k) - 17'h1;
    t = ({1'b0, x} & mask) + ({1'b0, y} & mask) + {16'h0, c};
    return t[k];
  endfunction

  task automatic chk(input string req, input logic [16:0] act, input logic [16:0] exp);
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (a=%h b=%h ci=%b)", req, act, exp, a, b, ci);
    end
  endtask

  // Drive at negedge, sample at posedge.
  task automatic apply(input logic [15:0] x, input logic [15:0] y, input logic c);
    logic [16:0] r;
    @(negedge clk);
    a = x; b = y; ci = c;
    @(posedge clk);
    #1;
    n_vec++;
    r = ref_add(x, y, c);
    chk("R1", {1'b0, sum}, {1'b0, r[15:0]});
    chk("R2", {16'h0, co}, {16'h0, r[16]});
    for (int k = 4; k < 16; k += 4)
      chk("R3", {16'h0, sum[k] ^ a[k] ^ b[k]}, {16'h0, ref_carry(x, y, c, k)});
  endtask

  task automatic apply_exp(input string req, input logic [15:0] x, input logic [15:0] y,
                           input logic c, input logic [15:0] es, input logic ec);
    apply(x, y, c);
    chk(req, {co, sum}, {ec, es});
  endtask

  initial begin
    a = '0; b = '0; ci = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    n_vec++;
    chk("R6", {co, sum}, 17'h0); // reset-time state with zero inputs
    rst_ni = 1'b1;

    apply_exp("R6", 16'h0000, 16'h0000, 1'b1, 16'h0001, 1'b0);
    apply_exp("R6", 16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0);
    apply_exp("R4", 16'hA5C3, 16'h5A3C, 1'b1, 16'h0000, 1'b1);
    apply_exp("R4", 16'h0000, 16'hFFFF, 1'b1, 16'h0000, 1'b1);
    apply_exp("R5", 16'h1234, 16'hEDCB, 1'b0, 16'hFFFF, 1'b0);
    apply_exp("R7", 16'hFFFF, 16'hFFFF, 1'b1, 16'hFFFF, 1'b1);
    apply_exp("R8", 16'h0001, 16'hFFFF, 1'b0, 16'h0000, 1'b1);
    apply_exp("R9", 16'h8888, 16'h8888, 1'b0, 16'h1110, 1'b1);
    apply_exp("R3", 16'h000F, 16'h0001, 1'b0, 16'h0010, 1'b0);
    apply_exp("R3", 16'h0FFF, 16'h0000, 1'b1, 16'h1000, 1'b0);
    apply_exp("R3", 16'h00FF, 16'h0F01, 1'b0, 16'h1000, 1'b0);

    // Corner grid: every pair from a small set, both carry-ins.
    begin
      logic [15:0] pats [8] = '{16'h0000, 16'hFFFF, 16'h8000, 16'h0001,
                                16'h7FFF, 16'h0F0F, 16'hF0F0, 16'h5555};
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          for (int c = 0; c < 2; c++)
            apply(pats[i], pats[j], c[0]);
    end

    // Constrained random: half the cases force adjacent groups into full propagate.
    void'($urandom(32'h00C1_A16E));
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] x, y;
      x = 16'($urandom);
      y = 16'($urandom);
      if (n[0]) y = (~x & 16'hFFF0) | (y & 16'h000F);
      apply(x, y, 1'($urandom));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule